// File: doc/BRIEF.md
# Ping-Pong Successive-Approximation Controller

This block sequences a 10-bit charge-redistribution converter built from two capacitive DAC channels used in alternation. While one channel follows the analog input, the other holds the sample it took during the previous sampling period and is resolved bit by bit against a single shared comparator. A period-start strobe marks each sampling boundary. At every strobe the channels exchange roles, so each conversion has a whole sampling period to finish. At the nominal 100 MHz clock and 200 ns period that is 20 cycles: one settle cycle, ten decision cycles, and nine idle cycles.

The controller drives a trial code to each DAC and a track-select to each channel. It reads the comparator decision, which is 1 when the held sample is at or above the converting channel's trial code. It returns each finished word together with a tag naming the channel that produced it. If a strobe arrives before the tenth decision, the conversion is cut short. The bits decided so far are reported with an overrun flag, and the roles swap as usual.

The result interface carries no back-pressure. A word appears with a single-cycle `res_valid` pulse, and the consumer must capture it in that cycle.

Top module: `pp_sar_ctrl`

## Requirements
- R1: While reset is asserted and until the first strobe, `track_a` is 1, `track_b` is 0, both trial codes are 0 and `res_valid` is 0.
- R2: At every clock edge where `period_start` is 1, the track-selects swap: exactly one of `track_a`/`track_b` is 1 at all times. Without a strobe they hold.
- R3: The first strobe after reset starts no conversion, so no `res_valid` pulse occurs before the second strobe.
- R4: At each later strobe, the channel that was tracking becomes the converter. Its trial code is 10'b1000000000 in the cycle after the strobe (the settle cycle). Its decisions are then taken MSB first on the next ten edges. A comparator value of 1 keeps the current bit, 0 clears it, and the next lower bit is set as the new trial.
- R5: After the tenth decision, `res_valid` is 1 for exactly one cycle. `res_data` holds the final code, `res_overrun` is 0, and `res_chan` is 0 for channel A and 1 for channel B. The result appears on the cycle after the 11th edge following the strobe.
- R6: If a strobe arrives while a conversion is unfinished, `res_valid` is 1 in the next cycle with `res_overrun` 1 and the converting channel's tag. `res_data` keeps the bits already decided and has all undecided bits at 0. The comparator is not sampled at that edge, and the new conversion starts normally.
- R7: The trial code of the tracking channel is 0.
- R8: After a conversion completes, the converting channel's trial code holds the final word until the next strobe, whatever the comparator does.
- R9: `res_valid` is 1 only in the cycles named in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_start | input | 1 | Sampling-period boundary strobe, one cycle per boundary |
| cmp_keep | input | 1 | Comparator decision: 1 when held sample is at or above the converting trial code |
| trial_a | output | 10 | Trial code for DAC channel A |
| trial_b | output | 10 | Trial code for DAC channel B |
| track_a | output | 1 | Channel A follows the input |
| track_b | output | 1 | Channel B follows the input |
| res_valid | output | 1 | Single-cycle result strobe |
| res_data | output | 10 | Converted word |
| res_chan | output | 1 | Channel that produced the word (0 = A, 1 = B) |
| res_overrun | output | 1 | Word is partial because the period ended early |

## Verification
The assertions assume that `period_start` and `cmp_keep` are known and stable around every rising edge once reset is released. They also assume the comparator value matters only while a channel is converting. Strobes may be any distance apart, back to back included.

The stimulus changes inputs only on falling edges. It derives the comparator from a behavioural model of the held sample against the converting trial code, and it drives random comparator values whenever no conversion is running. Period lengths cover the nominal 20 cycles, the exact 11-edge boundary, and several early cuts.

// File: rtl/pp_sar_pkg.sv
package pp_sar_pkg;
  // the scheme is ping-pong: two DAC channels alternate roles
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_DECIDE = 2'd2
  } phase_e;
endpackage

// File: rtl/pp_sar_roles.sv
module pp_sar_roles #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           period_start,
  output logic [NCH-1:0] track_vec,
  output logic           primed
);
  // one-hot rotation of the tracking role; primed after first boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track_vec <= NCH'(1);
      primed    <= 1'b0;
    end else if (period_start) begin
      track_vec <= {track_vec[NCH-2:0], track_vec[NCH-1]};
      primed    <= 1'b1;
    end
  end

  // R2
  role_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(track_vec) == 1);
endmodule

// File: rtl/pp_sar_engine.sv
module pp_sar_engine
  import pp_sar_pkg::*;
#(
  parameter int unsigned NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_start,
  input  logic             is_tracking,
  input  logic             primed,
  input  logic             cmp_keep,
  output logic [NBITS-1:0] code_o,
  output logic             busy_o,
  output logic             req_o,
  output logic             ovr_o,
  output logic [NBITS-1:0] word_o
);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  phase_e           ph_q;
  logic [NBITS-1:0] code_q;
  logic [NBITS-1:0] ptr_q;   // one-hot: bit under trial
  logic [NBITS-1:0] decide_word;
  logic             last_dec;

  // keep or drop the trial bit, then raise the next lower one
  assign decide_word = (cmp_keep ? code_q : (code_q & ~ptr_q)) | (ptr_q >> 1);
  assign last_dec    = (ph_q == PH_DECIDE) && ptr_q[0];
  assign busy_o      = (ph_q != PH_IDLE);
  assign ovr_o       = period_start && busy_o;
  assign req_o       = ovr_o || (last_dec && !period_start);
  assign word_o      = ovr_o ? (code_q & ~ptr_q) : decide_word;
  assign code_o      = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      code_q <= '0;
      ptr_q  <= '0;
    end else if (period_start) begin
      if (is_tracking && primed) begin
        ph_q   <= PH_SETTLE;
        code_q <= MSB_ONE;
        ptr_q  <= MSB_ONE;
      end else begin
        ph_q   <= PH_IDLE;
        code_q <= '0;
        ptr_q  <= '0;
      end
    end else begin
      unique case (ph_q)
        PH_SETTLE: ph_q <= PH_DECIDE;
        PH_DECIDE: begin
          code_q <= decide_word;
          ptr_q  <= ptr_q >> 1;
          if (ptr_q[0]) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R7
  track_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_tracking |-> code_q == '0);
  // R4
  settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && is_tracking && primed) |=> (code_q == MSB_ONE && ph_q == PH_SETTLE));
  // R4
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $countones(ptr_q) == 1);
  // R8
  hold_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !period_start) |=> $stable(code_q));
endmodule

// File: rtl/pp_sar_result.sv
module pp_sar_result #(
  parameter int unsigned NBITS = 10,
  parameter int unsigned NCH   = 2,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_vec,
  input  logic [NCH-1:0]   ovr_vec,
  input  logic [NBITS-1:0] word_in [NCH],
  output logic             res_valid,
  output logic [NBITS-1:0] res_data,
  output logic [CH_W-1:0]  res_chan,
  output logic             res_overrun
);
  logic             sel_any;
  logic [CH_W-1:0]  sel_idx;
  logic [NBITS-1:0] sel_word;
  logic             sel_ovr;

  always_comb begin
    sel_any  = 1'b0;
    sel_idx  = '0;
    sel_word = '0;
    sel_ovr  = 1'b0;
    for (int i = 0; i < int'(NCH); i++) begin
      if (req_vec[i] && !sel_any) begin
        sel_any  = 1'b1;
        sel_idx  = CH_W'(i);
        sel_word = word_in[i];
        sel_ovr  = ovr_vec[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_chan    <= '0;
      res_overrun <= 1'b0;
    end else begin
      res_valid <= sel_any;
      if (sel_any) begin
        res_data    <= sel_word;
        res_chan    <= sel_idx;
        res_overrun <= sel_ovr;
      end
    end
  end

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_vec) <= 1);
endmodule

// File: rtl/pp_sar_ctrl.sv
module pp_sar_ctrl
  import pp_sar_pkg::*;
#(
  parameter int unsigned NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_start,
  input  logic             cmp_keep,
  output logic [NBITS-1:0] trial_a,
  output logic [NBITS-1:0] trial_b,
  output logic             track_a,
  output logic             track_b,
  output logic             res_valid,
  output logic [NBITS-1:0] res_data,
  output logic             res_chan,
  output logic             res_overrun
);
  logic [NUM_CH-1:0] track_vec;
  logic              primed;
  logic [NUM_CH-1:0] req_vec, ovr_vec, busy_vec;
  logic [NBITS-1:0]  code_arr [NUM_CH];
  logic [NBITS-1:0]  word_arr [NUM_CH];

  pp_sar_roles #(.NCH(NUM_CH)) u_roles (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .track_vec    (track_vec),
    .primed       (primed)
  );

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
    pp_sar_engine #(.NBITS(NBITS)) u_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .period_start (period_start),
      .is_tracking  (track_vec[g]),
      .primed       (primed),
      .cmp_keep     (cmp_keep),
      .code_o       (code_arr[g]),
      .busy_o       (busy_vec[g]),
      .req_o        (req_vec[g]),
      .ovr_o        (ovr_vec[g]),
      .word_o       (word_arr[g])
    );
  end

  pp_sar_result #(.NBITS(NBITS), .NCH(NUM_CH)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vec     (req_vec),
    .ovr_vec     (ovr_vec),
    .word_in     (word_arr),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_chan    (res_chan),
    .res_overrun (res_overrun)
  );

  assign trial_a = code_arr[0];
  assign trial_b = code_arr[1];
  assign track_a = track_vec[0];
  assign track_b = track_vec[1];

  // R2
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> track_a != $past(track_a));
  // R2
  track_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable({track_a, track_b}));
  // R3
  first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !primed) |=> !res_valid);
  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && (|busy_vec)) |=> (res_valid && res_overrun));
  // R5
  complete_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_overrun) |-> !$past(period_start));
endmodule

// File: tb/pp_sar_ctrl_tb.sv
module pp_sar_ctrl_tb;
  localparam int NB = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          period_start = 1'b0;
  logic          cmp_keep = 1'b0;
  logic [NB-1:0] trial_a, trial_b;
  logic          track_a, track_b;
  logic          res_valid, res_chan, res_overrun;
  logic [NB-1:0] res_data;

  pp_sar_ctrl #(.NBITS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .cmp_keep(cmp_keep),
    .trial_a(trial_a), .trial_b(trial_b), .track_a(track_a), .track_b(track_b),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .res_overrun(res_overrun)
  );

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int top_mask(input int n);
    if (n <= 0) return 0;
    return ((1 << NB) - 1) ^ ((1 << (NB - n)) - 1);
  endfunction

  // behavioural reference model
  int m_tsel, m_conv, m_cnt, ain, nd;
  bit m_primed, m_busy, m_hold, m_first;
  int samp [2];
  bit exp_valid, exp_ovr;
  int exp_data, exp_ch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tsel = 0; m_conv = 1; m_cnt = 0;
      m_primed = 0; m_busy = 0; m_hold = 0; m_first = 0;
      exp_valid = 0; exp_ovr = 0; exp_data = 0; exp_ch = 0;
      samp[0] = 0; samp[1] = 0;
    end else begin
      exp_valid = 0;
      if (period_start) begin
        if (m_busy) begin
          nd = (m_cnt >= 1) ? m_cnt - 1 : 0;
          exp_valid = 1; exp_ovr = 1; exp_ch = m_conv;
          exp_data = samp[m_conv] & top_mask(nd);
        end
        samp[m_tsel] = ain;
        m_conv = m_tsel;
        m_tsel = 1 - m_tsel;
        m_busy = m_primed;
        m_first = !m_primed;
        m_primed = 1;
        m_cnt = 0;
        m_hold = 0;
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == NB + 1) begin
          exp_valid = 1; exp_ovr = 0; exp_ch = m_conv;
          exp_data = samp[m_conv];
          m_busy = 0; m_hold = 1;
        end
      end
    end
  end

  // per-cycle comparison and comparator model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      int conv_trial, trk_trial;
      conv_trial = (m_conv == 0) ? int'(trial_a) : int'(trial_b);
      trk_trial  = (m_tsel == 0) ? int'(trial_a) : int'(trial_b);
      check(track_a == (m_tsel == 0) && track_b == (m_tsel == 1), "R2", "track_a",
            int'(track_a), int'(m_tsel == 0));
      check(res_valid == exp_valid, m_first ? "R3" : "R9", "res_valid",
            int'(res_valid), int'(exp_valid));
      if (exp_valid && res_valid) begin
        check(int'(res_data) == exp_data, exp_ovr ? "R6" : "R5", "res_data",
              int'(res_data), exp_data);
        check(int'(res_chan) == exp_ch, exp_ovr ? "R6" : "R5", "res_chan",
              int'(res_chan), exp_ch);
        check(res_overrun == exp_ovr, exp_ovr ? "R6" : "R5", "res_overrun",
              int'(res_overrun), int'(exp_ovr));
      end
      check(trk_trial == 0, "R7", "tracking trial", trk_trial, 0);
      if (m_busy && m_cnt == 0)
        check(conv_trial == (1 << (NB - 1)), "R4", "settle trial", conv_trial, 1 << (NB - 1));
      if (m_hold)
        check(conv_trial == samp[m_conv], "R8", "held trial", conv_trial, samp[m_conv]);
      if (m_busy) cmp_keep <= (samp[m_conv] >= conv_trial);
      else        cmp_keep <= 1'($urandom % 2);
    end
  end

  task automatic run_period(input int len, input int val);
    ain = val;
    period_start = 1'b1;
    @(negedge clk);
    period_start = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(track_a == 1 && track_b == 0, "R1", "track in reset", int'(track_a), 1);
    check(trial_a == 0 && trial_b == 0, "R1", "trials in reset", int'(trial_a | trial_b), 0);
    check(res_valid == 0, "R1", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(track_a == 1 && trial_b == 0 && res_valid == 0, "R1", "idle before strobe",
          int'(track_a), 1);
    // nominal periods
    run_period(20, 300);
    run_period(20, 0);
    run_period(20, 1023);
    run_period(20, 512);
    run_period(20, 511);
    run_period(20, 1);
    run_period(20, 777);
    // early boundaries and the exact completion edge
    run_period(1, 640);
    run_period(2, 901);
    run_period(3, 333);
    run_period(7, 1000);
    run_period(11, 682);
    run_period(12, 85);
    run_period(11, 1023);
    run_period(1, 2);
    run_period(1, 700);
    run_period(20, 455);
    for (int k = 0; k < 40; k++) run_period(20, int'($urandom % 1024));
    run_period(20, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule